// File: doc/BRIEF.md
# Machine Trap Vector Register and Handler Address Unit

This block holds the machine-level trap vector of a RISC-V style core and works out where the core fetches next when a trap is taken. The register has two fields. A mode field sits in bits 1:0. A base field fills the upper bits and gives the handler address, which is always word aligned. Software reaches the register through the core's control-register port with read, write, bit-set and bit-clear accesses. The block decodes the register address, checks that the access comes from machine privilege, and legalises each written value so that a reserved mode can never be stored.

When the pipeline signals a trap, the block returns the handler address in the same cycle. The address depends on the trap cause, on whether the trap is an interrupt, and on the stored mode. In direct mode every trap goes to the base address. In vectored mode an interrupt goes to base plus four times its cause code, and a synchronous exception still goes to the base address. Cause and return-address registers and the pipeline flush belong to other blocks.

Top module: `trap_vec_unit`

## Requirements
- R1: Only an access with csr_addr equal to 12'h305 selects the register. Any other address leaves csr_hit and csr_illegal low, drives csr_rdata to zero and never changes the register.
- R2: MODE is held in bits 1:0 of the register (0 = direct, 1 = vectored). BASE is held in bits XLEN-1:2. Bits 1:0 of every trap target are zero.
- R3: In direct mode, trap_target equals BASE with two zero low bits, for interrupts and for exceptions alike.
- R4: In vectored mode, an interrupt (trap_is_irq=1) gives trap_target = BASE + 4*trap_cause, and an exception (trap_is_irq=0) gives trap_target = BASE.
- R5: A write that would leave MODE at 2 or 3 keeps the previous MODE and still updates BASE from the written value.
- R6: A selected access with csr_priv below 3 (3 = machine) raises csr_illegal, returns csr_rdata of zero and leaves the register unchanged.
- R7: csr_op encodes 0 = read, 1 = write, 2 = set (OR), 3 = clear (AND-NOT). Set and clear change only the bits that are one in csr_wdata and keep all other bits.
- R8: A set or clear with csr_wdata of zero, and any read access, never write the register. A legal selected access returns the current register value on csr_rdata in the same cycle.
- R9: After reset, BASE holds RESET_VECTOR with bits 1:0 cleared and MODE is 0.
- R10: trap_target is combinational from the register, trap_cause and trap_is_irq, and is valid in the cycle trap_valid is high. It is zero while trap_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_valid | input | 1 | A register access is presented this cycle |
| csr_op | input | 2 | Access kind: 0 read, 1 write, 2 set, 3 clear |
| csr_addr | input | 12 | Register address of the access |
| csr_priv | input | 2 | Privilege of the access, 3 is machine |
| csr_wdata | input | XLEN | Write value or bit mask |
| csr_rdata | output | XLEN | Current register value for a legal selected access, else zero |
| csr_hit | output | 1 | Access selects this register and is allowed |
| csr_illegal | output | 1 | Access selects this register from too low a privilege |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_is_irq | input | 1 | The trap is an interrupt (1) or a synchronous exception (0) |
| trap_cause | input | CAUSE_W | Cause code of the trap |
| trap_target | output | XLEN | Handler address for the trap |

## Verification
The bench reads the register back after every access, so each decode and legalisation path can be seen at the ports. Random accesses mix the four kinds, wrong addresses and low privileges, so a wrong mask, a missed privilege check or a stray write all show up as a difference from the model. Trap requests in both modes are each tried as an interrupt and as an exception with random cause codes. This separates direct from vectored handling and an interrupt offset from an exception offset. Directed cases cover reserved mode writes, set and clear with a zero mask, the largest cause code, and trap_valid low.

// File: rtl/trap_vec_pkg.sv
// Shared definitions for the trap vector unit: access kinds, mode codes
// and the register address. Assumes a 12-bit register address space.
package trap_vec_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_SET   = 2'd2,
        ACC_CLEAR = 2'd3
    } acc_kind_e;

    localparam logic [1:0]  MODE_DIRECT   = 2'd0;
    localparam logic [1:0]  MODE_VECTORED = 2'd1;
    localparam logic [1:0]  PRIV_MACHINE  = 2'd3;
    localparam logic [11:0] TVEC_ADDR     = 12'h305;
endpackage

// File: rtl/trap_vec_decode.sv
// Access decoder: selects the register by address, checks privilege and
// forms the raw value an access would store. Assumes the current register
// value is presented on cur_val in the same cycle.
module trap_vec_decode
    import trap_vec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            acc_valid,
    input  logic [1:0]      acc_kind,
    input  logic [11:0]     acc_addr,
    input  logic [1:0]      acc_priv,
    input  logic [XLEN-1:0] acc_data,
    input  logic [XLEN-1:0] cur_val,
    output logic            sel_ok,
    output logic            sel_bad,
    output logic            upd_en,
    output logic [XLEN-1:0] upd_raw
);
    logic      addr_match;
    acc_kind_e kind;

    assign kind = acc_kind_e'(acc_kind);

    // Purpose: address and privilege qualification of the access.
    always_comb begin
        addr_match = acc_valid && (acc_addr == TVEC_ADDR);
        sel_ok     = addr_match && (acc_priv == PRIV_MACHINE);
        sel_bad    = addr_match && (acc_priv != PRIV_MACHINE);
    end

    // Purpose: raw update value and write enable per access kind.
    always_comb begin
        upd_raw = cur_val;
        upd_en  = 1'b0;
        unique case (kind)
            ACC_READ: begin
                upd_en = 1'b0;
            end
            ACC_WRITE: begin
                upd_raw = acc_data;
                upd_en  = sel_ok;
            end
            ACC_SET: begin
                upd_raw = cur_val | acc_data;
                upd_en  = sel_ok && (acc_data != '0);
            end
            ACC_CLEAR: begin
                upd_raw = cur_val & ~acc_data;
                upd_en  = sel_ok && (acc_data != '0);
            end
            default: begin
                upd_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/trap_vec_legalize.sv
// Field legaliser: keeps the previous mode when the requested mode is a
// reserved code, takes the base field as written. Assumes cur_val already
// holds a legal mode.
module trap_vec_legalize
    import trap_vec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cur_val,
    input  logic [XLEN-1:0] raw_val,
    output logic [XLEN-1:0] legal_val
);
    logic mode_reserved;

    // Purpose: merge written base with a legal mode field.
    always_comb begin
        mode_reserved = (raw_val[1:0] != MODE_DIRECT) && (raw_val[1:0] != MODE_VECTORED);
        legal_val     = {raw_val[XLEN-1:2], (mode_reserved ? cur_val[1:0] : raw_val[1:0])};
    end
endmodule

// File: rtl/trap_vec_target.sv
// Handler address generator: base for direct mode and for exceptions,
// base plus four times the cause for interrupts in vectored mode. Purely
// combinational; the sum wraps at XLEN bits.
module trap_vec_target
    import trap_vec_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input  logic [XLEN-3:0]    base_word,
    input  logic [1:0]         mode,
    input  logic               take,
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] cause,
    output logic [XLEN-1:0]    target
);
    localparam int OFS_W = CAUSE_W + 2;

    logic [XLEN-1:0] base_addr;
    logic [XLEN-1:0] irq_ofs;

    // Purpose: select the handler address for the current trap.
    always_comb begin
        base_addr = {base_word, 2'b00};
        irq_ofs   = XLEN'({cause, 2'b00});
        if (!take) begin
            target = '0;
        end else if ((mode == MODE_VECTORED) && is_irq) begin
            target = base_addr + irq_ofs;
        end else begin
            target = base_addr;
        end
    end

    logic unused_ok;
    assign unused_ok = (OFS_W > 0);
endmodule

// File: rtl/trap_vec_unit.sv
// Top of the trap vector unit: holds the register, wires the decoder,
// legaliser and target generator. Assumes a synchronous active-low reset
// and a RESET_VECTOR whose low two bits are ignored.
module trap_vec_unit
    import trap_vec_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter int              CAUSE_W      = 6,
    parameter logic [XLEN-1:0] RESET_VECTOR = XLEN'(32'h0000_0100)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_valid,
    input  logic [1:0]         csr_op,
    input  logic [11:0]        csr_addr,
    input  logic [1:0]         csr_priv,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    output logic               csr_hit,
    output logic               csr_illegal,
    input  logic               trap_valid,
    input  logic               trap_is_irq,
    input  logic [CAUSE_W-1:0] trap_cause,
    output logic [XLEN-1:0]    trap_target
);
    localparam logic [XLEN-1:0] RESET_VAL = {RESET_VECTOR[XLEN-1:2], MODE_DIRECT};

    logic [XLEN-1:0] csr_q;
    logic [XLEN-1:0] upd_raw;
    logic [XLEN-1:0] upd_legal;
    logic            upd_en;

    trap_vec_decode #(.XLEN(XLEN)) u_decode (
        .acc_valid (csr_valid),
        .acc_kind  (csr_op),
        .acc_addr  (csr_addr),
        .acc_priv  (csr_priv),
        .acc_data  (csr_wdata),
        .cur_val   (csr_q),
        .sel_ok    (csr_hit),
        .sel_bad   (csr_illegal),
        .upd_en    (upd_en),
        .upd_raw   (upd_raw)
    );

    trap_vec_legalize #(.XLEN(XLEN)) u_legal (
        .cur_val   (csr_q),
        .raw_val   (upd_raw),
        .legal_val (upd_legal)
    );

    trap_vec_target #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_target (
        .base_word (csr_q[XLEN-1:2]),
        .mode      (csr_q[1:0]),
        .take      (trap_valid),
        .is_irq    (trap_is_irq),
        .cause     (trap_cause),
        .target    (trap_target)
    );

    // Purpose: register storage with reset and legal update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q <= RESET_VAL;
        end else if (upd_en) begin
            csr_q <= upd_legal;
        end
    end

    // Purpose: read data only for a legal selected access.
    assign csr_rdata = csr_hit ? csr_q : '0;
endmodule

// File: rtl/trap_vec_checker.sv
// Property checker for trap_vec_unit, attached by bind. Observes ports and
// the stored register value.
module trap_vec_checker #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               csr_valid,
    input logic [1:0]         csr_op,
    input logic [11:0]        csr_addr,
    input logic [XLEN-1:0]    csr_wdata,
    input logic               csr_hit,
    input logic               csr_illegal,
    input logic               trap_valid,
    input logic               trap_is_irq,
    input logic [XLEN-1:0]    trap_target,
    input logic [XLEN-1:0]    csr_q
);
    assert_other_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_addr != 12'h305) |=> $stable(csr_q));

    assert_target_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (trap_target[1:0] == 2'b00));

    assert_direct_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && csr_q[1:0] == 2'd0) |-> (trap_target[XLEN-1:2] == csr_q[XLEN-1:2]));

    assert_vec_exception_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !trap_is_irq) |-> (trap_target[XLEN-1:2] == csr_q[XLEN-1:2]));

    assert_mode_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_q[1] == 1'b0));

    assert_illegal_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |=> $stable(csr_q));

    assert_hit_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_hit && csr_illegal));

    assert_zero_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_op[1] && csr_wdata == '0) |=> $stable(csr_q));

    assert_read_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_op == 2'd0) |=> $stable(csr_q));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |-> (trap_target == '0));
endmodule

bind trap_vec_unit trap_vec_checker #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_valid   (csr_valid),
    .csr_op      (csr_op),
    .csr_addr    (csr_addr),
    .csr_wdata   (csr_wdata),
    .csr_hit     (csr_hit),
    .csr_illegal (csr_illegal),
    .trap_valid  (trap_valid),
    .trap_is_irq (trap_is_irq),
    .trap_target (trap_target),
    .csr_q       (csr_q)
);

// File: tb/test_trap_vec_unit.sv
`timescale 1ns/1ps
module test_trap_vec_unit;
    localparam int          XLEN    = 32;
    localparam int          CAUSE_W = 6;
    localparam logic [31:0] RV      = 32'h0000_0100;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               csr_valid = 1'b0;
    logic [1:0]         csr_op = 2'd0;
    logic [11:0]        csr_addr = 12'h0;
    logic [1:0]         csr_priv = 2'd3;
    logic [XLEN-1:0]    csr_wdata = '0;
    logic [XLEN-1:0]    csr_rdata;
    logic               csr_hit;
    logic               csr_illegal;
    logic               trap_valid = 1'b0;
    logic               trap_is_irq = 1'b0;
    logic [CAUSE_W-1:0] trap_cause = '0;
    logic [XLEN-1:0]    trap_target;

    int n_chk = 0;
    int n_bad = 0;
    logic [XLEN-1:0] model;

    always #2.5 clk = ~clk;

    trap_vec_unit #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .RESET_VECTOR(RV)) i_trap_vec_unit (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_op(csr_op),
        .csr_addr(csr_addr), .csr_priv(csr_priv), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .csr_hit(csr_hit), .csr_illegal(csr_illegal),
        .trap_valid(trap_valid), .trap_is_irq(trap_is_irq),
        .trap_cause(trap_cause), .trap_target(trap_target)
    );

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Model of the next register value for one access.
    function automatic logic [XLEN-1:0] next_val(input logic [XLEN-1:0] cur, input logic [1:0] op,
                                                 input logic [11:0] addr, input logic [1:0] priv,
                                                 input logic [XLEN-1:0] d);
        logic [XLEN-1:0] raw;
        if (addr != 12'h305 || priv != 2'd3 || op == 2'd0) return cur;
        if (op != 2'd1 && d == '0) return cur;
        case (op)
            2'd1:    raw = d;
            2'd2:    raw = cur | d;
            default: raw = cur & ~d;
        endcase
        if (raw[1]) raw[1:0] = cur[1:0];
        return raw;
    endfunction

    function automatic logic [XLEN-1:0] exp_target(input logic [XLEN-1:0] r, input logic irq,
                                                   input logic [CAUSE_W-1:0] c);
        logic [XLEN-1:0] b;
        b = {r[XLEN-1:2], 2'b00};
        if (r[1:0] == 2'd1 && irq) return b + (XLEN'(c) << 2);
        return b;
    endfunction

    // One access: checks same-cycle outputs, then updates model at the edge.
    task automatic access(input logic [1:0] op, input logic [11:0] addr, input logic [1:0] priv,
                          input logic [XLEN-1:0] d, input string tag);
        logic sel;
        @(negedge clk);
        csr_valid = 1'b1; csr_op = op; csr_addr = addr; csr_priv = priv; csr_wdata = d;
        #1;
        sel = (addr == 12'h305);
        check({tag, " hit (R1/R6)"}, XLEN'(csr_hit), XLEN'(sel && priv == 2'd3));
        check({tag, " illegal (R6)"}, XLEN'(csr_illegal), XLEN'(sel && priv != 2'd3));
        check({tag, " rdata (R8)"}, csr_rdata, (sel && priv == 2'd3) ? model : '0);
        @(posedge clk);
        model = next_val(model, op, addr, priv, d);
        @(negedge clk);
        csr_valid = 1'b0;
    endtask

    task automatic readback(input string tag);
        @(negedge clk);
        csr_valid = 1'b1; csr_op = 2'd0; csr_addr = 12'h305; csr_priv = 2'd3; csr_wdata = '0;
        #1;
        check(tag, csr_rdata, model);
        @(negedge clk);
        csr_valid = 1'b0;
    endtask

    task automatic trap(input logic irq, input logic [CAUSE_W-1:0] c, input string tag);
        @(negedge clk);
        trap_valid = 1'b1; trap_is_irq = irq; trap_cause = c;
        #1;
        check(tag, trap_target, exp_target(model, irq, c));
        trap_valid = 1'b0;
        #1;
        check("R10 target zero when idle", trap_target, '0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd12345;
        void'($urandom(seed));
        model = {RV[XLEN-1:2], 2'b00};
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        readback("R9 reset value");
        trap(1'b1, 6'd7, "R3 direct irq after reset");
        trap(1'b0, 6'd2, "R3 direct exception");

        access(2'd1, 12'h305, 2'd3, 32'h8000_0201, "R2 write vectored");
        readback("R2 readback vectored");
        trap(1'b1, 6'd3, "R4 vectored irq");
        trap(1'b0, 6'd11, "R4 vectored exception");
        trap(1'b1, 6'd63, "R4 vectored max cause");

        access(2'd1, 12'h305, 2'd3, 32'h1234_5602, "R5 reserved mode 2");
        readback("R5 base updated mode kept");
        access(2'd2, 12'h305, 2'd3, 32'h0000_0002, "R5 set to mode 3");
        readback("R5 set reserved kept");

        access(2'd2, 12'h305, 2'd3, '0, "R8 set zero");
        access(2'd3, 12'h305, 2'd3, '0, "R8 clear zero");
        readback("R8 unchanged");

        access(2'd3, 12'h305, 2'd3, 32'h1200_0001, "R7 clear bits");
        readback("R7 after clear");
        access(2'd2, 12'h305, 2'd3, 32'h0000_F000, "R7 set bits");
        readback("R7 after set");

        access(2'd1, 12'h305, 2'd1, 32'hFFFF_FFFD, "R6 low priv");
        readback("R6 unchanged");
        access(2'd1, 12'h306, 2'd3, 32'hDEAD_BEE1, "R1 wrong addr");
        readback("R1 unchanged");

        for (int i = 0; i < 400; i++) begin
            logic [1:0]  op;
            logic [11:0] a;
            logic [1:0]  p;
            logic [31:0] d;
            op = 2'($urandom_range(0, 3));
            a  = ($urandom_range(0, 7) == 0) ? 12'($urandom) : 12'h305;
            p  = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 2)) : 2'd3;
            d  = ($urandom_range(0, 7) == 0) ? 32'd0 : $urandom;
            access(op, a, p, d, "R7 random access");
            trap(1'($urandom), CAUSE_W'($urandom), "R4 random trap");
        end
        readback("R7 final readback");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule